// File: doc/BRIEF.md
# Triggered Delay Counter with Pulse-Out

This block measures programmable delays from a start event. While it is enabled, a start event clears an internal counter to zero and starts it counting up, one step per clock. The counter is compared against a set of active compare values. One pair of values shapes a single pulse-out window: one value sets the pulse and the other clears it. Each channel also has its own delay value. When the counter reaches that value, the channel's pre-trigger output is raised. The counter stops and holds when it reaches the active modulus.

A start event comes from one of two places, picked by a select field. It is either a rising edge on one external trigger line, which is synchronized inside the block, or a control write that sets the soft-start bit when the select field holds the soft code. Register writes go into shadow copies only. The shadow copies are moved into the active set when a load request is pending and one of two things is true: the counter reaches the modulus, or the block is disabled. The load request then clears itself. Register reads always return the active values.

The sequencer has four states:
- OFF: the block is disabled.
- WAIT: the block is enabled and waiting for the first start event.
- RUN: the counter is counting.
- HOLD: the counter has stopped at the modulus.

The transitions are:
- Any state goes to OFF when the block is disabled.
- Any state goes to RUN on a start event.
- OFF goes to WAIT when the block is enabled.
- RUN goes to HOLD when the count equals the modulus.

Top module: `trig_delay_pulser`

## Requirements
- R1: Each external trigger line passes through a two-stage synchronizer and an edge register. A rising edge on the line chosen by control bits 11:8 (values 0 to N_TRIG-1) is a start event, and the counter reads 0 on the third clock edge after the line rises. Edges on lines that are not selected have no effect on the count.
- R2: A write to control (address 0) with bit 2 set is a start event when the select field held before that write is 15 (soft code). The counter reads 0 right after that write's clock edge.
- R3: A start event sets the count to 0 and enters RUN. In RUN the count goes up by one on each clock. When it equals the active modulus it enters HOLD and keeps that value.
- R4: When enable (control bit 0) is 0, the block is in OFF. In OFF the count is 0, pulse-out and all pre-triggers are low, and start events are ignored.
- R5: Writes to the modulus register (address 1), the pulse register (address 2: set value in bits 16 and up, clear value in bits 0 and up) and the channel registers (address 3 + channel) change only the shadow copies. Reading those addresses returns the active values, zero-extended.
- R6: Writing control bit 1 as 1 sets a pending load request, which reads back in bit 1. While enabled, the load takes place on the clock edge where the count equals the modulus in RUN. After the load the request clears itself.
- R7: While enable is 0, a pending load takes place on the next clock edge.
- R8: Pulse-out rises one clock after RUN sees the count equal to the active set value. It falls one clock after RUN sees the count equal to the active clear value. When the two values are equal, the clear wins.
- R9: Pre-trigger n rises one clock after RUN sees the count equal to channel n's active delay. It falls on the clock edge of the next start event.
- R10: After reset the following hold: control reads 0, the modulus reads all ones, the pulse register and the channel registers read 0, and the count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_in | input | N_TRIG | External trigger lines, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 32 | Read data of the active values, combinational |
| cnt_out | output | CNT_W | Current count |
| pulse_out | output | 1 | Pulse-out window |
| pretrig | output | N_CH | Per-channel pre-trigger outputs |

## Verification
The bench builds the block with an 8-bit counter, three channels and four trigger lines. With these values, modulus values of a few dozen are reached many times in a run. Every compare value can land before, on or after the modulus. This brings these cases within reach: loads taken at the modulus, clear values equal to set values, delays that are never reached, and restarts in the middle of a count. With three channels and four lines, the bench can check channel independence and the rejection of edges on unselected lines. Select codes that name no line are also drawn, and they must never start the count.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
    typedef enum logic [1:0] {
        ST_OFF,
        ST_WAIT,
        ST_RUN,
        ST_HOLD
    } seq_state_t;

    localparam int        REG_CTRL  = 0;
    localparam int        REG_MOD   = 1;
    localparam int        REG_PULSE = 2;
    localparam int        REG_CH0   = 3;
    localparam int        SEL_W     = 4;
    localparam logic [3:0] SEL_SOFT = 4'hF;

    localparam int BIT_EN   = 0;
    localparam int BIT_LDOK = 1;
    localparam int BIT_SOFT = 2;
    localparam int SEL_LSB  = 8;
endpackage

// File: rtl/tdc_trig_sel.sv
module tdc_trig_sel
    import tdc_pkg::*;
#(
    parameter int N_TRIG = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_TRIG-1:0] trig_in,
    input  logic [SEL_W-1:0]  sel,
    input  logic              soft_req,
    input  logic              enable,
    output logic              start_evt
);
    logic [N_TRIG-1:0] sync1_q, sync2_q, hist_q;
    logic [N_TRIG-1:0] rise;
    logic              picked;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= '0;
            sync2_q <= '0;
            hist_q  <= '0;
        end else begin
            sync1_q <= trig_in;
            sync2_q <= sync1_q;
            hist_q  <= sync2_q;
        end
    end

    assign rise = sync2_q & ~hist_q;

    always_comb begin
        picked = 1'b0;
        for (int i = 0; i < N_TRIG; i++) begin
            if (sel == SEL_W'(i)) picked = rise[i];
        end
    end

    assign start_evt = enable && ((sel == SEL_SOFT) ? soft_req : picked);
endmodule

// File: rtl/tdc_regs.sv
module tdc_regs
    import tdc_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int N_CH   = 4,
    parameter int ADDR_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [31:0]                wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [31:0]                rd_data,
    input  logic                       at_mod,
    output logic                       enable,
    output logic [SEL_W-1:0]           sel,
    output logic                       soft_req,
    output logic                       ldok,
    output logic                       load_fire,
    output logic [CNT_W-1:0]           act_mod,
    output logic [CNT_W-1:0]           act_set,
    output logic [CNT_W-1:0]           act_clr,
    output logic [N_CH-1:0][CNT_W-1:0] act_ch
);
    logic [CNT_W-1:0]           sh_mod, sh_set, sh_clr;
    logic [N_CH-1:0][CNT_W-1:0] sh_ch;
    logic                       wr_ctrl, wr_mod, wr_pulse;

    assign wr_ctrl  = wr_en && (wr_addr == ADDR_W'(REG_CTRL));
    assign wr_mod   = wr_en && (wr_addr == ADDR_W'(REG_MOD));
    assign wr_pulse = wr_en && (wr_addr == ADDR_W'(REG_PULSE));
    assign soft_req = wr_ctrl && wr_data[BIT_SOFT];

    assign load_fire = ldok && (!enable || at_mod);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable  <= 1'b0;
            sel     <= '0;
            ldok    <= 1'b0;
            sh_mod  <= '1;
            sh_set  <= '0;
            sh_clr  <= '0;
            act_mod <= '1;
            act_set <= '0;
            act_clr <= '0;
        end else begin
            if (wr_ctrl) begin
                enable <= wr_data[BIT_EN];
                sel    <= wr_data[SEL_LSB +: SEL_W];
            end
            if (wr_ctrl && wr_data[BIT_LDOK]) ldok <= 1'b1;
            else if (load_fire)                ldok <= 1'b0;
            if (wr_mod) sh_mod <= wr_data[CNT_W-1:0];
            if (wr_pulse) begin
                sh_set <= wr_data[16 +: CNT_W];
                sh_clr <= wr_data[0 +: CNT_W];
            end
            if (load_fire) begin
                act_mod <= sh_mod;
                act_set <= sh_set;
                act_clr <= sh_clr;
            end
        end
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sh_ch[c]  <= '0;
                act_ch[c] <= '0;
            end else begin
                if (wr_en && (wr_addr == ADDR_W'(REG_CH0 + c))) sh_ch[c] <= wr_data[CNT_W-1:0];
                if (load_fire) act_ch[c] <= sh_ch[c];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(REG_CTRL)) begin
            rd_data[BIT_EN]              = enable;
            rd_data[BIT_LDOK]            = ldok;
            rd_data[SEL_LSB +: SEL_W]    = sel;
        end else if (rd_addr == ADDR_W'(REG_MOD)) begin
            rd_data = 32'(act_mod);
        end else if (rd_addr == ADDR_W'(REG_PULSE)) begin
            rd_data = {16'(act_set), 16'(act_clr)};
        end
        for (int c = 0; c < N_CH; c++) begin
            if (rd_addr == ADDR_W'(REG_CH0 + c)) rd_data = 32'(act_ch[c]);
        end
    end
endmodule

// File: rtl/tdc_seq.sv
module tdc_seq
    import tdc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             start_evt,
    input  logic [CNT_W-1:0] modulus,
    output logic [CNT_W-1:0] cnt,
    output seq_state_t       state,
    output logic             running,
    output logic             at_mod
);
    seq_state_t       state_d;
    logic [CNT_W-1:0] cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
            cnt   <= '0;
        end else begin
            state <= state_d;
            cnt   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state;
        cnt_d   = cnt;
        if (!enable) begin
            state_d = ST_OFF;
            cnt_d   = '0;
        end else if (start_evt) begin
            state_d = ST_RUN;
            cnt_d   = '0;
        end else begin
            unique case (state)
                ST_OFF:  state_d = ST_WAIT;
                ST_WAIT: state_d = ST_WAIT;
                ST_RUN: begin
                    if (cnt == modulus) state_d = ST_HOLD;
                    else                cnt_d   = cnt + 1'b1;
                end
                ST_HOLD: state_d = ST_HOLD;
                default: state_d = ST_OFF;
            endcase
        end
    end

    always_comb begin
        running = (state == ST_RUN);
        at_mod  = running && (cnt == modulus);
    end
endmodule

// File: rtl/tdc_outgen.sv
module tdc_outgen #(
    parameter int CNT_W = 16,
    parameter int N_CH  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       enable,
    input  logic                       start_evt,
    input  logic                       running,
    input  logic [CNT_W-1:0]           cnt,
    input  logic [CNT_W-1:0]           set_val,
    input  logic [CNT_W-1:0]           clr_val,
    input  logic [N_CH-1:0][CNT_W-1:0] ch_val,
    output logic                       pulse_out,
    output logic [N_CH-1:0]            pretrig
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           pulse_out <= 1'b0;
        else if (!enable)                     pulse_out <= 1'b0;
        else if (running && cnt == clr_val)   pulse_out <= 1'b0;
        else if (running && cnt == set_val)   pulse_out <= 1'b1;
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_pre
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          pretrig[c] <= 1'b0;
            else if (!enable || start_evt)       pretrig[c] <= 1'b0;
            else if (running && cnt == ch_val[c]) pretrig[c] <= 1'b1;
        end
    end
endmodule

// File: rtl/trig_delay_pulser.sv
module trig_delay_pulser
    import tdc_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int N_CH   = 4,
    parameter int N_TRIG = 4,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_TRIG-1:0] trig_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    output logic [CNT_W-1:0]  cnt_out,
    output logic              pulse_out,
    output logic [N_CH-1:0]   pretrig
);
    logic                       enable, soft_req, ldok, load_fire, start_evt;
    logic                       running, at_mod;
    logic [SEL_W-1:0]           sel;
    logic [CNT_W-1:0]           act_mod, act_set, act_clr, cnt;
    logic [N_CH-1:0][CNT_W-1:0] act_ch;
    seq_state_t                 state;

    tdc_regs #(.CNT_W(CNT_W), .N_CH(N_CH), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .at_mod(at_mod), .enable(enable), .sel(sel),
        .soft_req(soft_req), .ldok(ldok), .load_fire(load_fire), .act_mod(act_mod),
        .act_set(act_set), .act_clr(act_clr), .act_ch(act_ch)
    );

    tdc_trig_sel #(.N_TRIG(N_TRIG)) u_trig (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .sel(sel), .soft_req(soft_req),
        .enable(enable), .start_evt(start_evt)
    );

    tdc_seq #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start_evt(start_evt), .modulus(act_mod),
        .cnt(cnt), .state(state), .running(running), .at_mod(at_mod)
    );

    tdc_outgen #(.CNT_W(CNT_W), .N_CH(N_CH)) u_out (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start_evt(start_evt), .running(running),
        .cnt(cnt), .set_val(act_set), .clr_val(act_clr), .ch_val(act_ch),
        .pulse_out(pulse_out), .pretrig(pretrig)
    );

    assign cnt_out = cnt;
endmodule

// File: rtl/trig_delay_pulser_chk.sv
module trig_delay_pulser_chk #(
    parameter int CNT_W  = 16,
    parameter int N_CH   = 4,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [31:0]       wr_data,
    input logic              enable,
    input logic              start_evt,
    input logic              running,
    input logic              ldok,
    input logic              load_fire,
    input logic [CNT_W-1:0]  cnt_out,
    input logic [CNT_W-1:0]  act_mod,
    input logic [CNT_W-1:0]  act_set,
    input logic [CNT_W-1:0]  act_clr,
    input logic              pulse_out,
    input logic [N_CH-1:0]   pretrig
);
    logic ldok_write;
    assign ldok_write = wr_en && (wr_addr == '0) && wr_data[1];

    assert_restart_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (cnt_out == '0) && running);

    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && enable && !start_evt && cnt_out != act_mod) |=> cnt_out == $past(cnt_out) + 1'b1);

    assert_no_overrun_R3: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> cnt_out <= act_mod);

    assert_off_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!pulse_out && pretrig == '0 && cnt_out == '0));

    assert_active_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !load_fire |=> ($stable(act_mod) && $stable(act_set) && $stable(act_clr)));

    assert_ldok_selfclear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_fire && !ldok_write) |=> !ldok);

    assert_pulse_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_out) |-> $past(running && cnt_out == act_set));

    assert_pulse_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulse_out) |-> $past(!enable || (running && cnt_out == act_clr)));
endmodule

bind trig_delay_pulser trig_delay_pulser_chk #(.CNT_W(CNT_W), .N_CH(N_CH), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .enable(enable), .start_evt(start_evt), .running(running), .ldok(ldok),
    .load_fire(load_fire), .cnt_out(cnt_out), .act_mod(act_mod), .act_set(act_set),
    .act_clr(act_clr), .pulse_out(pulse_out), .pretrig(pretrig)
);

// File: tb/trig_delay_pulser_test.sv
`timescale 1ns/1ps
module trig_delay_pulser_test;
    localparam int CNT_W  = 8;
    localparam int N_CH   = 3;
    localparam int N_TRIG = 4;
    localparam int ADDR_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N_TRIG-1:0] trig_in = '0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [31:0]       rd_data;
    logic [CNT_W-1:0]  cnt_out;
    logic              pulse_out;
    logic [N_CH-1:0]   pretrig;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    trig_delay_pulser #(.CNT_W(CNT_W), .N_CH(N_CH), .N_TRIG(N_TRIG), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .cnt_out(cnt_out),
        .pulse_out(pulse_out), .pretrig(pretrig)
    );

    // Reference model built from the requirements
    logic [N_TRIG-1:0] ms1, ms2, ms3;
    logic              men, mldok, mpulse;
    logic [3:0]        msel;
    logic [1:0]        mst;
    logic [CNT_W-1:0]  mcnt, sh_mod, sh_set, sh_clr, ac_mod, ac_set, ac_clr;
    logic [CNT_W-1:0]  sh_ch [N_CH];
    logic [CNT_W-1:0]  ac_ch [N_CH];
    logic [N_CH-1:0]   mpre;
    logic              m_sw, m_evt, m_run, m_ld, m_ldset, m_pick;
    logic [N_TRIG-1:0] m_rise;

    always_comb begin
        m_rise  = ms2 & ~ms3;
        m_sw    = wr_en && wr_addr == 4'd0 && wr_data[2];
        m_ldset = wr_en && wr_addr == 4'd0 && wr_data[1];
        m_pick  = 1'b0;
        for (int i = 0; i < N_TRIG; i++) if (msel == 4'(i)) m_pick = m_rise[i];
        m_evt   = men && ((msel == 4'hF) ? m_sw : m_pick);
        m_run   = (mst == 2'd2);
        m_ld    = mldok && (!men || (m_run && mcnt == ac_mod));
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ms1 <= '0; ms2 <= '0; ms3 <= '0;
            men <= 1'b0; mldok <= 1'b0; msel <= '0; mst <= 2'd0; mcnt <= '0;
            mpulse <= 1'b0; mpre <= '0;
            sh_mod <= '1; ac_mod <= '1; sh_set <= '0; sh_clr <= '0; ac_set <= '0; ac_clr <= '0;
            for (int c = 0; c < N_CH; c++) begin sh_ch[c] <= '0; ac_ch[c] <= '0; end
        end else begin
            ms1 <= trig_in; ms2 <= ms1; ms3 <= ms2;
            if (!men) begin mst <= 2'd0; mcnt <= '0; end
            else if (m_evt) begin mst <= 2'd2; mcnt <= '0; end
            else if (mst == 2'd0) mst <= 2'd1;
            else if (m_run) begin
                if (mcnt == ac_mod) mst <= 2'd3;
                else mcnt <= mcnt + 1'b1;
            end
            if (!men) mpulse <= 1'b0;
            else if (m_run && mcnt == ac_clr) mpulse <= 1'b0;
            else if (m_run && mcnt == ac_set) mpulse <= 1'b1;
            for (int c = 0; c < N_CH; c++) begin
                if (!men || m_evt) mpre[c] <= 1'b0;
                else if (m_run && mcnt == ac_ch[c]) mpre[c] <= 1'b1;
            end
            if (m_ldset) mldok <= 1'b1;
            else if (m_ld) mldok <= 1'b0;
            if (m_ld) begin
                ac_mod <= sh_mod; ac_set <= sh_set; ac_clr <= sh_clr;
                for (int c = 0; c < N_CH; c++) ac_ch[c] <= sh_ch[c];
            end
            if (wr_en) begin
                if (wr_addr == 4'd0) begin men <= wr_data[0]; msel <= wr_data[11:8]; end
                if (wr_addr == 4'd1) sh_mod <= wr_data[CNT_W-1:0];
                if (wr_addr == 4'd2) begin sh_set <= wr_data[16 +: CNT_W]; sh_clr <= wr_data[0 +: CNT_W]; end
                for (int c = 0; c < N_CH; c++) if (wr_addr == 4'(3 + c)) sh_ch[c] <= wr_data[CNT_W-1:0];
            end
        end
    end

    function automatic logic [31:0] model_read(input logic [3:0] a);
        logic [31:0] r;
        r = '0;
        if (a == 4'd0) r = {20'd0, msel, 6'd0, mldok, men};
        else if (a == 4'd1) r = 32'(ac_mod);
        else if (a == 4'd2) r = {16'(ac_set), 16'(ac_clr)};
        for (int c = 0; c < N_CH; c++) if (a == 4'(3 + c)) r = 32'(ac_ch[c]);
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Continuous comparison against the model, away from the clock edge
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            check("R3 count", 32'(cnt_out), 32'(mcnt));
            check("R8 pulse", 32'(pulse_out), 32'(mpulse));
            check("R9 pretrig", 32'(pretrig), 32'(mpre));
            check("R5 readback", rd_data, model_read(rd_addr));
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
        rd_addr = a;
        #0.5;
        check(req, rd_data, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [3:0]  a;
        void'($urandom(32'd1234));
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R10 reset values
        rd_chk("R10 ctrl", 4'd0, 32'h0);
        rd_chk("R10 modulus", 4'd1, 32'h0000_00FF);
        rd_chk("R10 pulse reg", 4'd2, 32'h0);
        rd_chk("R10 channel", 4'd3, 32'h0);
        check("R10 count", 32'(cnt_out), 32'h0);
        // R5 shadow writes have no visible effect
        wr(4'd1, 32'd20);
        wr(4'd2, 32'h0005_000C);
        wr(4'd3, 32'd3);
        wr(4'd4, 32'd8);
        wr(4'd5, 32'd15);
        rd_chk("R5 pulse still active", 4'd2, 32'h0);
        rd_chk("R5 modulus still active", 4'd1, 32'h0000_00FF);
        // R7 load while disabled
        wr(4'd0, 32'h2);
        rd_chk("R6 request pending", 4'd0, 32'h2);
        tick(1);
        rd_chk("R7 pulse loaded", 4'd2, 32'h0005_000C);
        rd_chk("R7 modulus loaded", 4'd1, 32'd20);
        rd_chk("R6 request cleared", 4'd0, 32'h0);
        // R1 select line 1, edge on line 2 ignored
        wr(4'd0, 32'h101);
        trig_in = 4'b0100;
        tick(6);
        check("R1 unselected ignored", 32'(cnt_out), 32'h0);
        trig_in = 4'b0110;
        tick(6);
        check("R1 selected edge starts", 32'(cnt_out), 32'd3);
        tick(1);
        check("R9 channel 0 raised", 32'(pretrig), 32'b001);
        tick(2);
        check("R8 pulse set", 32'(pulse_out), 32'h1);
        tick(7);
        check("R8 pulse cleared", 32'(pulse_out), 32'h0);
        // R2 soft start
        wr(4'd0, 32'hF01);
        wr(4'd0, 32'hF05);
        check("R2 soft start", 32'(cnt_out), 32'h0);
        check("R9 cleared by restart", 32'(pretrig), 32'h0);
        tick(2);
        check("R2 counting", 32'(cnt_out), 32'd2);
        // R6 load at modulus while running
        wr(4'd2, 32'h0007_0009);
        wr(4'd0, 32'hF03);
        rd_chk("R6 pending while running", 4'd0, 32'hF03);
        rd_chk("R5 old pulse active", 4'd2, 32'h0005_000C);
        tick(25);
        check("R3 held at modulus", 32'(cnt_out), 32'd20);
        rd_chk("R6 loaded at modulus", 4'd2, 32'h0007_0009);
        rd_chk("R6 cleared after load", 4'd0, 32'hF01);
        // R4 disabled ignores soft start
        wr(4'd0, 32'hF00);
        tick(1);
        check("R4 count zero", 32'(cnt_out), 32'h0);
        check("R4 pulse low", 32'(pulse_out), 32'h0);
        wr(4'd0, 32'hF04);
        tick(2);
        check("R4 start ignored", 32'(cnt_out), 32'h0);
        check("R4 pretrig low", 32'(pretrig), 32'h0);
        // Random phase, checked by the model comparison
        for (int k = 0; k < 6000; k++) begin
            if ($urandom % 20 == 0) trig_in[$urandom % N_TRIG] = ~trig_in[$urandom % N_TRIG];
            rd_addr = 4'($urandom % 7);
            if ($urandom % 12 == 0) begin
                a = 4'($urandom % 6);
                if (a == 4'd0) begin
                    v = '0;
                    v[0] = ($urandom % 8) != 0;
                    v[1] = ($urandom % 3) == 0;
                    v[2] = ($urandom % 2) == 0;
                    case ($urandom % 6)
                        0: v[11:8] = 4'hF;
                        1: v[11:8] = 4'h7;
                        default: v[11:8] = 4'($urandom % N_TRIG);
                    endcase
                end else if (a == 4'd1) v = 32'(10 + $urandom % 50);
                else if (a == 4'd2) v = {16'($urandom % 64), 16'($urandom % 64)};
                else v = 32'($urandom % 64);
                wr(a, v);
            end else begin
                tick(1);
            end
        end
        tick(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule